// File: doc/BRIEF.md
# Emergency Power Source Selection Controller

This synchronous controller governs the emergency electrical configuration that an aircraft enters after every main AC bus has failed. It decides when to command the air-driven emergency turbine out. It decides when the emergency generator may be energized from the turbine-driven hydraulic circuit. It also picks which source feeds the essential AC bus and which feeds the essential DC bus. All inputs are single-bit flags that are already qualified upstream. Airspeed reaches the block only as an "above threshold" flag, with the threshold at 100 knots.

The turbine command has two sources. The automatic one fires when every main bus is lost and the airspeed flag is high. The manual one is a guarded button that works in any configuration, including a cold and unpowered aircraft. Once the command is given it stays set, because the turbine cannot be stowed in flight. A ground test mode lets maintenance connect the generator while a hydraulic pump override and a test button are both held. A fault lamp reports a turbine that has not extended, after a programmable settling delay.

Top module: `eps_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output takes its reset value after that edge: deploy 0, generator enable 0, lamp 0, `ess_ac_sel` = 2'b01 and `ess_dc_sel` = 2'b01.
- R2: When every bit of `main_ok` is 0 and `spd_high` is 1 at an edge, `turb_deploy` is 1 after that edge.
- R3: When at least one main bus is healthy, or `spd_high` is 0, the automatic condition does not set `turb_deploy`.
- R4: `manual_on` high at an edge sets `turb_deploy` after that edge, whatever the other inputs are.
- R5: Once set, `turb_deploy` stays 1 until a reset, even if the buses recover or the airspeed flag drops.
- R6: `gen_enable` follows (deploy command AND NOT `gear_down`) OR test mode, with the same one-edge latency as `turb_deploy`. With the gear compressed and no test mode, the generator is never enabled.
- R7: Test mode is `hyd_ovrd` AND `gen_test`, both high at the same edge. The generator is connected only at edges where both are high, whatever the gear state.
- R8: When `gen_avail` is 0 or `gear_down` is 1, `ess_ac_sel` is 2'b01 (static inverter) and `ess_dc_sel` is 2'b01 (battery 2) after the edge.
- R9: When `gen_avail` is 1 and `gear_down` is 0, `ess_ac_sel` is 2'b10 (emergency generator) and `ess_dc_sel` is 2'b10 (essential transformer-rectifier) after the edge.
- R10: After every edge, each of `ess_ac_sel` and `ess_dc_sel` has exactly one bit set.
- R11: The lamp condition is: all main buses lost and `turb_ext` low. `fault_lamp` rises at the (SETTLE_CYC+1)-th consecutive edge at which the condition holds, and not before.
- R12: `fault_lamp` is 0 after the first edge at which the lamp condition is false. The settling count then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| main_ok | input | N_MAIN | One bit per main AC bus, 1 = bus powered |
| spd_high | input | 1 | Airspeed above deployment threshold |
| gear_down | input | 1 | Landing gear compressed (weight on wheels) |
| turb_ext | input | 1 | Turbine extended feedback |
| gen_avail | input | 1 | Emergency generator output within limits |
| manual_on | input | 1 | Guarded manual turbine command |
| hyd_ovrd | input | 1 | Hydraulic pump override active |
| gen_test | input | 1 | Generator test button held |
| turb_deploy | output | 1 | Turbine deploy command (latched) |
| gen_enable | output | 1 | Emergency generator connect |
| fault_lamp | output | 1 | Red fault lamp |
| ess_ac_sel | output | 2 | Essential AC source, bit0 inverter, bit1 generator |
| ess_dc_sel | output | 2 | Essential DC source, bit0 battery 2, bit1 transformer-rectifier |

## Verification
A corrupted deploy latch shows at `turb_deploy` and `gen_enable` on the very next edge. A command that clears once the buses come back is the most telling symptom, and it appears one cycle after recovery. A wrong settling count appears only at the lamp. It shows as a rise one or more edges early or late against the SETTLE_CYC+1 boundary, so the lamp is sampled on every edge around that boundary. A bad source register shows within one edge as a select code with zero or two bits set, or as the generator path chosen while the gear is compressed.

// File: rtl/eps_pkg.sv
package eps_pkg;

    // One-hot source codes; bit positions are decoded by the bus contactors.
    typedef enum logic [1:0] {
        AC_FROM_INV = 2'b01,
        AC_FROM_GEN = 2'b10
    } ac_src_e;

    typedef enum logic [1:0] {
        DC_FROM_BAT = 2'b01,
        DC_FROM_TRU = 2'b10
    } dc_src_e;

    typedef struct packed {
        logic deployed;
    } deploy_st_t;

    typedef struct packed {
        logic gen_on;
    } gen_st_t;

    typedef struct packed {
        ac_src_e ac;
        dc_src_e dc;
    } src_st_t;

endpackage

// File: rtl/eps_deploy_latch.sv
module eps_deploy_latch
    import eps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic auto_req,
    input  logic manual_req,
    output logic deploy_next,
    output logic deploy
);

    deploy_st_t st_d, st_q;

    // Set-only latch: the turbine cannot be stowed once out.
    always_comb begin
        st_d = st_q;
        if (auto_req || manual_req) begin
            st_d.deployed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign deploy_next = st_d.deployed;
    assign deploy      = st_q.deployed;

endmodule

// File: rtl/eps_gen_ctl.sv
module eps_gen_ctl
    import eps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic deploy_next,
    input  logic gear_down,
    input  logic hyd_ovrd,
    input  logic gen_test,
    output logic gen_enable
);

    gen_st_t st_d, st_q;
    logic    test_mode;
    logic    flight_ok;

    assign test_mode = hyd_ovrd & gen_test;
    assign flight_ok = deploy_next & ~gear_down;

    always_comb begin
        st_d        = st_q;
        st_d.gen_on = flight_ok | test_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gen_enable = st_q.gen_on;

endmodule

// File: rtl/eps_bus_select.sv
module eps_bus_select
    import eps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       gen_avail,
    input  logic       gear_down,
    output logic [1:0] ac_sel,
    output logic [1:0] dc_sel
);

    src_st_t st_d, st_q;
    logic    gen_path;

    assign gen_path = gen_avail & ~gear_down;

    // Both selects come out of one register, so no cycle ever carries two sources.
    always_comb begin
        st_d = st_q;
        if (gen_path) begin
            st_d.ac = AC_FROM_GEN;
            st_d.dc = DC_FROM_TRU;
        end else begin
            st_d.ac = AC_FROM_INV;
            st_d.dc = DC_FROM_BAT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ac <= AC_FROM_INV;
            st_q.dc <= DC_FROM_BAT;
        end else begin
            st_q <= st_d;
        end
    end

    assign ac_sel = st_q.ac;
    assign dc_sel = st_q.dc;

endmodule

// File: rtl/eps_fault_timer.sv
module eps_fault_timer #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    output logic lamp
);

    localparam int CNT_W = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lamp;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cond) begin
            st_d.lamp = (st_q.cnt == CNT_MAX);
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt  = '0;
            st_d.lamp = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lamp = st_q.lamp;

endmodule

// File: rtl/eps_ctrl.sv
module eps_ctrl #(
    parameter int N_MAIN     = 2,
    parameter int SETTLE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_MAIN-1:0] main_ok,
    input  logic              spd_high,
    input  logic              gear_down,
    input  logic              turb_ext,
    input  logic              gen_avail,
    input  logic              manual_on,
    input  logic              hyd_ovrd,
    input  logic              gen_test,
    output logic              turb_deploy,
    output logic              gen_enable,
    output logic              fault_lamp,
    output logic [1:0]        ess_ac_sel,
    output logic [1:0]        ess_dc_sel
);

    logic all_lost;
    logic auto_req;
    logic deploy_next;
    logic lamp_cond;

    assign all_lost  = ~|main_ok;
    assign auto_req  = all_lost & spd_high;
    assign lamp_cond = all_lost & ~turb_ext;

    eps_deploy_latch u_deploy (
        .clk         (clk),
        .rst         (rst),
        .auto_req    (auto_req),
        .manual_req  (manual_on),
        .deploy_next (deploy_next),
        .deploy      (turb_deploy)
    );

    eps_gen_ctl u_gen (
        .clk         (clk),
        .rst         (rst),
        .deploy_next (deploy_next),
        .gear_down   (gear_down),
        .hyd_ovrd    (hyd_ovrd),
        .gen_test    (gen_test),
        .gen_enable  (gen_enable)
    );

    eps_bus_select u_sel (
        .clk       (clk),
        .rst       (rst),
        .gen_avail (gen_avail),
        .gear_down (gear_down),
        .ac_sel    (ess_ac_sel),
        .dc_sel    (ess_dc_sel)
    );

    eps_fault_timer #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .cond (lamp_cond),
        .lamp (fault_lamp)
    );

endmodule

// File: rtl/eps_ctrl_chk.sv
module eps_ctrl_chk #(
    parameter int N_MAIN = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [N_MAIN-1:0] main_ok,
    input logic              spd_high,
    input logic              gear_down,
    input logic              turb_ext,
    input logic              gen_avail,
    input logic              manual_on,
    input logic              hyd_ovrd,
    input logic              gen_test,
    input logic              turb_deploy,
    input logic              gen_enable,
    input logic              fault_lamp,
    input logic [1:0]        ess_ac_sel,
    input logic [1:0]        ess_dc_sel
);

    p_auto_deploy_r2: assert property (@(posedge clk) disable iff (rst)
        (main_ok == '0 && spd_high) |=> turb_deploy);

    p_manual_deploy_r4: assert property (@(posedge clk) disable iff (rst)
        manual_on |=> turb_deploy);

    p_deploy_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        turb_deploy |=> turb_deploy);

    p_gear_blocks_gen_r6: assert property (@(posedge clk) disable iff (rst)
        (gear_down && !(hyd_ovrd && gen_test)) |=> !gen_enable);

    p_test_connects_r7: assert property (@(posedge clk) disable iff (rst)
        (hyd_ovrd && gen_test) |=> gen_enable);

    p_fallback_src_r8: assert property (@(posedge clk) disable iff (rst)
        (gear_down || !gen_avail) |=> (ess_ac_sel == 2'b01 && ess_dc_sel == 2'b01));

    p_gen_src_r9: assert property (@(posedge clk) disable iff (rst)
        (gen_avail && !gear_down) |=> (ess_ac_sel == 2'b10 && ess_dc_sel == 2'b10));

    p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        ($countones(ess_ac_sel) == 1 && $countones(ess_dc_sel) == 1));

    p_lamp_clear_r12: assert property (@(posedge clk) disable iff (rst)
        !(main_ok == '0 && !turb_ext) |=> !fault_lamp);

    p_lamp_needs_cond_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_lamp) |-> ($past(main_ok) == '0 && !$past(turb_ext)));

endmodule

bind eps_ctrl eps_ctrl_chk #(.N_MAIN(N_MAIN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .main_ok     (main_ok),
    .spd_high    (spd_high),
    .gear_down   (gear_down),
    .turb_ext    (turb_ext),
    .gen_avail   (gen_avail),
    .manual_on   (manual_on),
    .hyd_ovrd    (hyd_ovrd),
    .gen_test    (gen_test),
    .turb_deploy (turb_deploy),
    .gen_enable  (gen_enable),
    .fault_lamp  (fault_lamp),
    .ess_ac_sel  (ess_ac_sel),
    .ess_dc_sel  (ess_dc_sel)
);

// File: tb/tb_eps_ctrl.sv
module tb_eps_ctrl;

    localparam int TB_SETTLE = 5;
    localparam int WATCHDOG  = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] main_ok = 2'b11;
    logic       spd_high = 1'b0, gear_down = 1'b1, turb_ext = 1'b0, gen_avail = 1'b0;
    logic       manual_on = 1'b0, hyd_ovrd = 1'b0, gen_test = 1'b0;
    logic       turb_deploy, gen_enable, fault_lamp;
    logic [1:0] ess_ac_sel, ess_dc_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic       dep;
        logic       gen;
        logic       lamp;
        logic [1:0] ac;
        logic [1:0] dc;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    // bench model state
    logic m_dep = 1'b0;
    int   m_cnt = 0;

    always #4 clk = ~clk;

    eps_ctrl #(.N_MAIN(2), .SETTLE_CYC(TB_SETTLE)) dut (
        .clk(clk), .rst(rst), .main_ok(main_ok), .spd_high(spd_high),
        .gear_down(gear_down), .turb_ext(turb_ext), .gen_avail(gen_avail),
        .manual_on(manual_on), .hyd_ovrd(hyd_ovrd), .gen_test(gen_test),
        .turb_deploy(turb_deploy), .gen_enable(gen_enable), .fault_lamp(fault_lamp),
        .ess_ac_sel(ess_ac_sel), .ess_dc_sel(ess_dc_sel)
    );

    // Driver: expected result of the coming edge, from the requirements.
    task automatic step(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            logic lost, cond;
            lost = (main_ok == 2'b00);
            cond = lost && !turb_ext;
            if (rst) begin
                m_dep = 1'b0;
                m_cnt = 0;
                e.dep = 1'b0; e.gen = 1'b0; e.lamp = 1'b0;
                e.ac = 2'b01; e.dc = 2'b01;
            end else begin
                m_dep  = m_dep || (lost && spd_high) || manual_on;
                e.dep  = m_dep;
                e.gen  = (m_dep && !gear_down) || (hyd_ovrd && gen_test);
                e.lamp = cond && (m_cnt == TB_SETTLE);
                m_cnt  = cond ? ((m_cnt < TB_SETTLE) ? m_cnt + 1 : m_cnt) : 0;
                e.ac   = (gen_avail && !gear_down) ? 2'b10 : 2'b01;
                e.dc   = (gen_avail && !gear_down) ? 2'b10 : 2'b01;
            end
            e.tag = tag;
            exp_q.push_back(e);
            @(negedge clk);
        end
    endtask

    // Monitor: compare away from the edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if ({turb_deploy, gen_enable, fault_lamp, ess_ac_sel, ess_dc_sel} !==
                {e.dep, e.gen, e.lamp, e.ac, e.dc}) begin
                fails++;
                $display("FAIL %s: dep/gen/lamp/ac/dc actual %b/%b/%b/%b/%b expected %b/%b/%b/%b/%b",
                         e.tag, turb_deploy, gen_enable, fault_lamp, ess_ac_sel, ess_dc_sel,
                         e.dep, e.gen, e.lamp, e.ac, e.dc);
            end
            checks++;
            if ($countones(ess_ac_sel) != 1 || $countones(ess_dc_sel) != 1) begin
                fails++;
                $display("FAIL R10: selects actual %b/%b expected one-hot each",
                         ess_ac_sel, ess_dc_sel);
            end
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        step("R1", 3);
        rst = 1'b0;
        main_ok = 2'b11; spd_high = 1'b1; gear_down = 1'b0;
        step("R3", 3);
        main_ok = 2'b01;
        step("R3", 3);
        main_ok = 2'b00; spd_high = 1'b0;
        step("R3", 2);
        spd_high = 1'b1;
        step("R2", 1);
        step("R11", TB_SETTLE + 2);
        turb_ext = 1'b1;
        step("R12", 2);
        main_ok = 2'b11; spd_high = 1'b0;
        step("R5", 3);
        gen_avail = 1'b1;
        step("R9 R6", 2);
        gear_down = 1'b1;
        step("R8 R6", 2);
        gear_down = 1'b0; gen_avail = 1'b0;
        step("R8", 2);
        main_ok = 2'b00; turb_ext = 1'b0;
        step("R11", TB_SETTLE + 1);
        main_ok = 2'b10;
        step("R12", 2);
        rst = 1'b1;
        step("R1", 2);
        rst = 1'b0;
        main_ok = 2'b00; spd_high = 1'b0; gear_down = 1'b1; turb_ext = 1'b0;
        manual_on = 1'b1;
        step("R4", 1);
        manual_on = 1'b0;
        step("R5", 2);
        rst = 1'b1;
        step("R1", 1);
        rst = 1'b0;
        main_ok = 2'b11; gear_down = 1'b1;
        hyd_ovrd = 1'b1;
        step("R7", 2);
        gen_test = 1'b1;
        step("R7", 3);
        hyd_ovrd = 1'b0;
        step("R7", 2);
        hyd_ovrd = 1'b1;
        step("R7", 1);
        gen_test = 1'b0;
        step("R7", 2);
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule